// File: doc/BRIEF.md
# Chained Indirect Operand-Address Resolver

This unit works out the operand address for a word-addressed machine with 36-bit words and 18-bit addresses. A start strobe hands it a modifier word. The modifier holds an address field, a 4-bit index-register selector and one indirect flag. At every level the unit adds the selected index register to the address field, unless the selector is zero. It reads that register through a combinational port. If the indirect flag is clear, the sum is the answer. If the flag is set, the sum names a memory word. The unit fetches that word, decodes it with the same layout and repeats.

The memory side is a plain request/valid read port with one read in flight at a time. A chain stops in one of two ways. A one-cycle done pulse carries the final address. A one-cycle fault pulse reports that the chain wanted more indirect levels than the cap allows, so a looping chain cannot hang the machine.

Field layout of every modifier word: bit 22 is the indirect flag, bits 21:18 are the index selector and bits 17:0 are the address. Bits 35:23 are not decoded.

The controller has three states:
- ST_IDLE waits for a start.
- ST_RESOLVE forms the indexed sum and decides the outcome.
- ST_FETCH holds a memory read until it returns.

The transitions are:
- launch: ST_IDLE to ST_RESOLVE when start is sampled.
- finish: ST_RESOLVE to ST_IDLE with done, when the flag is clear.
- overflow: ST_RESOLVE to ST_IDLE with fault, when the flag is set and the cap is reached.
- descend: ST_RESOLVE to ST_FETCH otherwise.
- return: ST_FETCH to ST_RESOLVE when read data is valid.

Top module: `ea_chain_unit`

## Requirements
- R1: A modifier with the indirect flag (bit 22) clear and selector zero yields done_o high for exactly one cycle, two clock edges after start is sampled, with ea_o equal to bits 17:0. No memory read is made.
- R2: With a nonzero selector (bits 21:18), the index value on xdata_i is added to the address field. With selector zero, nothing is added, whatever register 0 holds.
- R3: The indexed sum wraps modulo 2^18.
- R4: With the indirect flag set, the indexed sum is issued as mem_addr_o. The returned word is decoded with the same bit positions (22 flag, 21:18 selector, 17:0 address), and bits 35:23 are ignored.
- R5: Indexing and indirection repeat at every level, for as many levels as the fetched words request.
- R6: A chain that completes within 32 indirect fetches ends with done. A chain that asks for a 33rd indirect fetch ends with fault_o for one cycle instead, with no done and no further reads. done and fault never coincide.
- R7: A start pulse while a resolution is in progress is ignored. The running chain's result is unchanged and no extra completion occurs.
- R8: mem_req_o stays high with a stable mem_addr_o until mem_valid_i is sampled, and drops in the next cycle. Only one read is outstanding.
- R9: The level count restarts with every start, so a full-length chain succeeds right after a faulted one.
- R10: After reset, done_o, fault_o and mem_req_o are low and ea_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin resolving instr_i |
| instr_i | input | 36 | Initial modifier word |
| xsel_o | output | 4 | Index register selector for the read port |
| xdata_i | input | 18 | Low 18 bits of the selected index register |
| mem_req_o | output | 1 | Indirect word read request |
| mem_addr_o | output | 18 | Read address, held while requesting |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 36 | Fetched indirect word |
| done_o | output | 1 | One-cycle completion pulse |
| ea_o | output | 18 | Final effective address |
| fault_o | output | 1 | One-cycle indirection-limit fault |

## Verification
The bench builds the unit with its default cap of 32 levels and the 36/18-bit widths. Long linear chains of 32 and 33 fetched words therefore probe the exact boundary on either side, and a self-pointing word probes the runaway case. The memory model's latency is varied from zero to several cycles, which exercises the request-hold rule and a start arriving mid-fetch. Index values with junk in their upper bits and sums near 2^18 reach the masking and wrap paths.

// File: rtl/ea_chain_pkg.sv
package ea_chain_pkg;
    localparam int WORD_W   = 36;
    localparam int ADDR_W   = 18;
    localparam int XSEL_W   = 4;
    localparam int IND_POS  = 22;
    localparam int XSEL_LSB = 18;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESOLVE,
        ST_FETCH
    } ea_state_e;

    typedef struct packed {
        logic              ind;
        logic [XSEL_W-1:0] xsel;
        logic [ADDR_W-1:0] addr;
    } modifier_t;
endpackage

// File: rtl/ea_mod_decode.sv
module ea_mod_decode
    import ea_chain_pkg::*;
(
    input  logic [IND_POS:0] word_i,
    output modifier_t        mod_o
);
    always_comb begin
        mod_o.ind  = word_i[IND_POS];
        mod_o.xsel = word_i[XSEL_LSB +: XSEL_W];
        mod_o.addr = word_i[ADDR_W-1:0];
    end
endmodule

// File: rtl/ea_index_add.sv
module ea_index_add #(
    parameter int ADDR_W = 18,
    parameter int XSEL_W = 4
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [XSEL_W-1:0] xsel_i,
    input  logic [ADDR_W-1:0] xdata_i,
    output logic [ADDR_W-1:0] sum_o
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = (xsel_i != '0) ? xdata_i : '0;
        sum_o  = base_i + offset;
    end
endmodule

// File: rtl/ea_level_ctr.sv
module ea_level_ctr #(
    parameter int MAX_LEVELS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic incr_i,
    output logic at_cap_o
);
    localparam int CNT_W = $clog2(MAX_LEVELS + 1);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_LEVELS);

    logic [CNT_W-1:0] level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       level_q <= '0;
        else if (clear_i) level_q <= '0;
        else if (incr_i)  level_q <= level_q + 1'b1;
    end

    assign at_cap_o = (level_q == CAP);

    a_r6_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= CAP);

    a_r6_no_incr_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (at_cap_o && !clear_i) |-> !incr_i);
endmodule

// File: rtl/ea_chain_unit.sv
module ea_chain_unit
    import ea_chain_pkg::*;
#(
    parameter int MAX_LEVELS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] instr_i,
    output logic [XSEL_W-1:0] xsel_o,
    input  logic [ADDR_W-1:0] xdata_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_valid_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] ea_o,
    output logic              fault_o
);
    ea_state_e         state_q, state_d;
    modifier_t         cur_q;
    modifier_t         instr_mod, fetch_mod;
    logic [ADDR_W-1:0] level_sum;
    logic              at_cap;
    logic              launch, descend;

    ea_mod_decode u_dec_instr (.word_i(instr_i[IND_POS:0]),     .mod_o(instr_mod));
    ea_mod_decode u_dec_fetch (.word_i(mem_rdata_i[IND_POS:0]), .mod_o(fetch_mod));

    ea_index_add #(.ADDR_W(ADDR_W), .XSEL_W(XSEL_W)) u_add (
        .base_i (cur_q.addr),
        .xsel_i (cur_q.xsel),
        .xdata_i(xdata_i),
        .sum_o  (level_sum)
    );

    assign launch  = (state_q == ST_IDLE) && start_i;
    assign descend = (state_q == ST_RESOLVE) && cur_q.ind && !at_cap;

    ea_level_ctr #(.MAX_LEVELS(MAX_LEVELS)) u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (launch),
        .incr_i  (descend),
        .at_cap_o(at_cap)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: launch, finish, overflow, descend, return
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_RESOLVE;
            ST_RESOLVE: begin
                if (!cur_q.ind)  state_d = ST_IDLE;
                else if (at_cap) state_d = ST_IDLE;
                else             state_d = ST_FETCH;
            end
            ST_FETCH:   if (mem_valid_i) state_d = ST_RESOLVE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            done_o     <= 1'b0;
            fault_o    <= 1'b0;
            ea_o       <= '0;
            mem_addr_o <= '0;
        end else begin
            done_o  <= 1'b0;
            fault_o <= 1'b0;
            unique case (state_q)
                ST_IDLE:    if (start_i) cur_q <= instr_mod;
                ST_RESOLVE: begin
                    if (!cur_q.ind) begin
                        done_o <= 1'b1;
                        ea_o   <= level_sum;
                    end else if (at_cap) begin
                        fault_o <= 1'b1;
                    end else begin
                        mem_addr_o <= level_sum;
                    end
                end
                ST_FETCH:   if (mem_valid_i) cur_q <= fetch_mod;
                default: ;
            endcase
        end
    end

    assign mem_req_o = (state_q == ST_FETCH);
    assign xsel_o    = cur_q.xsel;

    a_r6_done_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fault_o));

    a_r1_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_fault_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o);

    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    a_r8_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_valid_i) |=> !mem_req_o);

    a_r6_no_req_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !mem_req_o);
endmodule

// File: tb/test_ea_chain_unit.sv
module test_ea_chain_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [35:0] instr_i = '0;
    logic [3:0]  xsel_o;
    logic [17:0] xdata_i;
    logic        mem_req_o;
    logic [17:0] mem_addr_o;
    logic        mem_valid_i = 1'b0;
    logic [35:0] mem_rdata_i = '0;
    logic        done_o;
    logic [17:0] ea_o;
    logic        fault_o;

    int applied = 0;
    int miscompares = 0;
    int lat = 0;
    int fetches = 0;
    int hold_err = 0;
    int done_seen = 0;
    bit finished = 0;

    logic [35:0] xreg [16];
    logic [35:0] mem [int];

    always #2 clk = ~clk;   // 250 MHz

    assign xdata_i = xreg[xsel_o][17:0];

    ea_chain_unit i_ea_chain_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .xsel_o(xsel_o), .xdata_i(xdata_i), .mem_req_o(mem_req_o),
        .mem_addr_o(mem_addr_o), .mem_valid_i(mem_valid_i),
        .mem_rdata_i(mem_rdata_i), .done_o(done_o), .ea_o(ea_o),
        .fault_o(fault_o)
    );

    function automatic logic [35:0] mk(input logic ind, input logic [3:0] x,
                                       input logic [17:0] a);
        return {13'h0, ind, x, a};
    endfunction

    // vector: instr(36) exp_ea(18) exp_fault(1) exp_fetches(6)
    localparam int NV = 12;
    localparam logic [60:0] VEC [NV] = '{
        {36'h0_0000_ABCD | 36'hFF800_0000, 18'h0ABCD, 1'b0, 6'd0},  // R1, R4 junk
        {36'h0_0004_0100, 18'h00110, 1'b0, 6'd0},  // R2 sel 1
        {36'h0_0000_0100, 18'h00100, 1'b0, 6'd0},  // R2 sel 0
        {36'h0_0008_1000, 18'h01005, 1'b0, 6'd0},  // R2 sel 2, upper bits
        {36'h0_000C_0020, 18'h00010, 1'b0, 6'd0},  // R3 wrap
        {36'h0_0044_01F0, 18'h01234, 1'b0, 6'd1},  // R4 indexed indirect
        {36'h0_0040_0300, 18'h00055, 1'b0, 6'd2},  // R5 two levels
        {36'h0_0040_0100, 18'h02ABC, 1'b0, 6'd32}, // R6 exactly 32
        {36'h0_0040_00FF, 18'h00000, 1'b1, 6'd32}, // R6 33 levels
        {36'h0_0040_0500, 18'h00000, 1'b1, 6'd32}, // R6 self loop
        {36'h0_0040_0100, 18'h02ABC, 1'b0, 6'd32}, // R9 after fault
        {36'h0_0040_0600, 18'h00042, 1'b0, 6'd1}   // R4 fetched junk bits
    };

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            mem_valid_i = 1'b0;
            if (mem_req_o) begin
                automatic logic [17:0] a = mem_addr_o;
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    if (!mem_req_o || mem_addr_o != a) hold_err++;
                end
                mem_rdata_i = mem.exists(int'(a)) ? mem[int'(a)] : 36'h0;
                mem_valid_i = 1'b1;
                fetches++;
            end
        end
    end

    always @(negedge clk) if (done_o) done_seen++;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        applied++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [35:0] w);
        @(negedge clk);
        instr_i = w;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_end(output bit got_done, output bit got_fault,
                            output logic [17:0] ea, output bit timeout);
        timeout = 1'b1;
        got_done = 1'b0; got_fault = 1'b0; ea = '0;
        for (int c = 0; c < 2000; c++) begin
            if (done_o || fault_o) begin
                got_done = done_o; got_fault = fault_o; ea = ea_o;
                timeout = 1'b0;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    endtask

    initial begin
        #400000;
        applied++;
        miscompares++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        bit d, f, to;
        logic [17:0] ea;
        for (int i = 0; i < 16; i++) xreg[i] = 36'h0;
        xreg[0] = 36'h0_0000_0777;
        xreg[1] = 36'h0_0000_0010;
        xreg[2] = 36'hF_FFFC_0005;
        xreg[3] = 36'h0_0003_FFF0;
        mem[32'h200] = mk(0, 0, 18'h01234);
        mem[32'h300] = mk(1, 1, 18'h00400);
        mem[32'h410] = mk(0, 2, 18'h00050);
        for (int k = 0; k < 31; k++)
            mem[32'h100 + k] = mk(1, 0, 18'h00100 + 18'(k + 1));
        mem[32'h11F] = mk(0, 0, 18'h02ABC);
        mem[32'h0FF] = mk(1, 0, 18'h00100);
        mem[32'h500] = mk(1, 0, 18'h00500);
        mem[32'h600] = 36'hFFF80_0000 | mk(0, 0, 18'h00042);

        repeat (3) @(negedge clk);
        // R10 reset state
        check(!done_o && !fault_o && !mem_req_o && ea_o == 0, "R10", "reset outputs",
              {done_o, fault_o, mem_req_o, ea_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            lat = v % 3;
            fetches = 0;
            pulse_start(VEC[v][60:25]);
            wait_end(d, f, ea, to);
            check(!to && f == VEC[v][6], "R6", $sformatf("vec %0d fault", v),
                  {to, f}, VEC[v][6]);
            check(d == !VEC[v][6], "R1", $sformatf("vec %0d done", v), d, !VEC[v][6]);
            if (!VEC[v][6])
                check(ea == VEC[v][24:7], "R2", $sformatf("vec %0d ea (R3 R4 R5)", v),
                      ea, VEC[v][24:7]);
            @(negedge clk);
            check(!done_o && !fault_o, "R1", $sformatf("vec %0d pulse width", v),
                  {done_o, fault_o}, 0);
            check(fetches == int'(VEC[v][5:0]), "R5", $sformatf("vec %0d fetches", v),
                  fetches, VEC[v][5:0]);
        end

        // R1 latency: done two edges after start sampled
        lat = 0;
        @(negedge clk);
        instr_i = mk(0, 0, 18'h00777);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!done_o, "R1", "done too early", done_o, 0);
        @(negedge clk);
        check(done_o && ea_o == 18'h00777, "R1", "done timing", {done_o, ea_o}, {1'b1, 18'h00777});
        @(negedge clk);

        // R7 start while busy is ignored
        lat = 4;
        fetches = 0;
        done_seen = 0;
        pulse_start(mk(1, 0, 18'h00300));
        repeat (2) @(negedge clk);
        instr_i = mk(0, 0, 18'h3FFFF);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_end(d, f, ea, to);
        check(d && ea == 18'h00055, "R7", "busy start result", ea, 18'h00055);
        repeat (10) @(negedge clk);
        check(done_seen == 1, "R7", "completions", done_seen, 1);
        check(fetches == 2, "R7", "fetch count", fetches, 2);

        // R8 request hold during long latency
        check(hold_err == 0, "R8", "request hold", hold_err, 0);
        check(!mem_req_o, "R8", "idle request", mem_req_o, 0);

        finish_run();
    end
endmodule